// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver with Holding Register

This block receives asynchronous serial frames on a single line. A sample-clock enable arrives at sixteen times the bit rate. A falling edge on the idle-high line starts a frame. Every bit is sampled three times around its centre, and a two-out-of-three vote decides its value, so one-sample glitches are rejected. A start bit that does not vote low at its centre is treated as noise, and the receiver goes back to waiting.

Data bits are collected in a shift register. When the stop bit has been judged, the finished word goes to one of two places:
- **FIFO mode off:** the word is copied into a holding register, the full flag is raised and a one-cycle interrupt is pulsed.
- **FIFO mode on:** the word is handed to an external queue with a one-cycle push strobe, and the full flag is forced low.

A read strobe empties the holding register. If a new word arrives while the holding register is still full, the overrun flag is raised. Each completed frame also reports whether its stop bit was bad.

Top module: `uart_os_rx`

## Requirements
- R1: After reset, hold_data, push_data, buf_full, overrun, frame_err, push_valid and rx_irq are all 0.
- R2: A frame is one low start bit, 8 data bits with the least significant bit first, and one stop bit. Each bit lasts 16 sample enables. With fifo_mode low, a completed word appears on hold_data and buf_full becomes 1. hold_data changes only when a word is placed there.
- R3: Each bit is sampled at the 7th, 8th and 9th enable of its 16-enable period, counted from the enable on which the start edge is seen. The bit value is the majority of those three samples: one flipped sample has no effect, and two flipped samples invert the bit.
- R4: A start bit is accepted only if its voted value at mid-bit is 0. Otherwise the receiver returns to idle with no push, no interrupt and no change on any output.
- R5: With fifo_mode low, rx_irq pulses high for exactly one cycle, in the same cycle that buf_full shows the new word. With fifo_mode high, rx_irq never pulses.
- R6: With fifo_mode high, a completed word is output on push_data with a one-cycle push_valid pulse. buf_full reads 0 in that cycle, and hold_data keeps its value.
- R7: A one-cycle rd_strobe clears buf_full and overrun in the following cycle, unless a word completes in the same cycle.
- R8: If a word completes with fifo_mode low while buf_full is 1 and no read is present, overrun becomes 1 and hold_data takes the new word. overrun stays 1 until a read.
- R9: frame_err is updated at every completed frame. It is 1 when the voted stop bit is 0 and 0 when the voted stop bit is 1.
- R10: A new frame starts only on a high-to-low transition of the line. A line that stays low after a frame with a bad stop bit starts no further frame until it has gone high and then low again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Sample enable at 16 times the bit rate |
| rx_in | input | 1 | Serial receive line, idle high |
| fifo_mode | input | 1 | 1 sends words to the queue push port instead of the holding register |
| rd_strobe | input | 1 | Read of the holding register; clears full and overrun |
| hold_data | output | 8 | Holding register contents |
| buf_full | output | 1 | Holding register holds an unread word |
| overrun | output | 1 | A word overwrote an unread word |
| frame_err | output | 1 | Stop bit of the last completed frame was 0 |
| push_data | output | 8 | Word offered to the external queue |
| push_valid | output | 1 | One-cycle push strobe to the external queue |
| rx_irq | output | 1 | One-cycle receive interrupt (FIFO mode off) |

## Verification
The bench uses the default parameters: 8 data bits, 16 samples per bit and a two-stage input synchronizer. The sample enable is driven once every four clocks. This spacing lets every change on the line reach the sampler before the next enable arrives. As a result, the bench can place glitches of one or two enables exactly on the 8th and 9th sample points, cut a start pulse short before mid-bit, and hold a break after a bad stop bit. Random frames mix the two routing modes with reads that may or may not happen, so both the overrun path and the path that clears the full flag are reached many times.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_bit_sampler.sv
module rx_bit_sampler
  import uart_os_rx_pkg::*;
#(
  parameter int OS_RATE = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic restart,
  input  logic rx_s,
  output logic mid_strobe,
  output logic end_strobe,
  output logic vote
);
  localparam int CNT_W  = $clog2(OS_RATE);
  localparam int SAMP_A = OS_RATE / 2 - 2;
  localparam int SAMP_B = SAMP_A + 1;
  localparam int SAMP_C = SAMP_A + 2;

  logic [CNT_W-1:0] cnt;
  logic             smp_a;
  logic             smp_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      smp_a <= 1'b1;
      smp_b <= 1'b1;
    end else if (tick) begin
      if (restart) cnt <= '0;
      else         cnt <= cnt + 1'b1;
      if (cnt == CNT_W'(SAMP_A)) smp_a <= rx_s;
      if (cnt == CNT_W'(SAMP_B)) smp_b <= rx_s;
    end
  end

  assign mid_strobe = tick && !restart && (cnt == CNT_W'(SAMP_C));
  assign end_strobe = tick && !restart && (cnt == CNT_W'(OS_RATE - 1));
  assign vote       = maj3(smp_a, smp_b, rx_s);
endmodule

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl
  import uart_os_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 rx_s,
  input  logic                 mid_strobe,
  input  logic                 end_strobe,
  input  logic                 vote,
  output logic                 restart,
  output logic                 done,
  output logic [DATA_BITS-1:0] word,
  output logic                 stop_bad
);
  localparam int IDX_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

  rx_state_e            state;
  logic                 rx_prev;
  logic [IDX_W-1:0]     idx;
  logic [DATA_BITS-1:0] shreg;

  assign restart = (state == ST_IDLE) && tick && rx_prev && !rx_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      rx_prev  <= 1'b1;
      idx      <= '0;
      shreg    <= '0;
      done     <= 1'b0;
      word     <= '0;
      stop_bad <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) rx_prev <= rx_s;
      case (state)
        ST_IDLE: begin
          if (restart) state <= ST_START;
        end
        ST_START: begin
          if (mid_strobe && vote)  state <= ST_IDLE;
          else if (end_strobe) begin
            state <= ST_DATA;
            idx   <= '0;
          end
        end
        ST_DATA: begin
          if (mid_strobe) shreg <= {vote, shreg[DATA_BITS-1:1]};
          if (end_strobe) begin
            if (idx == IDX_W'(DATA_BITS - 1)) state <= ST_STOP;
            else                             idx   <= idx + 1'b1;
          end
        end
        ST_STOP: begin
          if (mid_strobe) begin
            done     <= 1'b1;
            word     <= shreg;
            stop_bad <= !vote;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_hold_stage.sv
module rx_hold_stage #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 done,
  input  logic [DATA_BITS-1:0] word,
  input  logic                 stop_bad,
  input  logic                 fifo_mode,
  input  logic                 rd_strobe,
  output logic [DATA_BITS-1:0] hold_data,
  output logic                 buf_full,
  output logic                 overrun,
  output logic                 frame_err,
  output logic [DATA_BITS-1:0] push_data,
  output logic                 push_valid,
  output logic                 rx_irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_data  <= '0;
      buf_full   <= 1'b0;
      overrun    <= 1'b0;
      frame_err  <= 1'b0;
      push_data  <= '0;
      push_valid <= 1'b0;
      rx_irq     <= 1'b0;
    end else begin
      push_valid <= 1'b0;
      rx_irq     <= 1'b0;
      if (done) begin
        frame_err <= stop_bad;
        if (fifo_mode) begin
          push_data  <= word;
          push_valid <= 1'b1;
          buf_full   <= 1'b0;
          overrun    <= overrun && !rd_strobe;
        end else begin
          hold_data <= word;
          buf_full  <= 1'b1;
          rx_irq    <= 1'b1;
          overrun   <= !rd_strobe && (overrun || buf_full);
        end
      end else if (rd_strobe) begin
        buf_full <= 1'b0;
        overrun  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx #(
  parameter int DATA_BITS   = 8,
  parameter int OS_RATE     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick16,
  input  logic                 rx_in,
  input  logic                 fifo_mode,
  input  logic                 rd_strobe,
  output logic [DATA_BITS-1:0] hold_data,
  output logic                 buf_full,
  output logic                 overrun,
  output logic                 frame_err,
  output logic [DATA_BITS-1:0] push_data,
  output logic                 push_valid,
  output logic                 rx_irq
);
  logic                 rx_s;
  logic                 restart;
  logic                 mid_strobe;
  logic                 end_strobe;
  logic                 vote;
  logic                 done;
  logic [DATA_BITS-1:0] word;
  logic                 stop_bad;

  rx_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .din(rx_in), .dout(rx_s)
  );

  rx_bit_sampler #(.OS_RATE(OS_RATE)) i_sampler (
    .clk(clk), .rst(rst), .tick(tick16), .restart(restart), .rx_s(rx_s),
    .mid_strobe(mid_strobe), .end_strobe(end_strobe), .vote(vote)
  );

  rx_frame_ctrl #(.DATA_BITS(DATA_BITS)) i_ctrl (
    .clk(clk), .rst(rst), .tick(tick16), .rx_s(rx_s),
    .mid_strobe(mid_strobe), .end_strobe(end_strobe), .vote(vote),
    .restart(restart), .done(done), .word(word), .stop_bad(stop_bad)
  );

  rx_hold_stage #(.DATA_BITS(DATA_BITS)) i_hold (
    .clk(clk), .rst(rst), .done(done), .word(word), .stop_bad(stop_bad),
    .fifo_mode(fifo_mode), .rd_strobe(rd_strobe),
    .hold_data(hold_data), .buf_full(buf_full), .overrun(overrun),
    .frame_err(frame_err), .push_data(push_data), .push_valid(push_valid),
    .rx_irq(rx_irq)
  );
endmodule

// File: rtl/uart_os_rx_chk.sv
module uart_os_rx_chk #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 fifo_mode,
  input logic                 rd_strobe,
  input logic [DATA_BITS-1:0] hold_data,
  input logic                 buf_full,
  input logic                 overrun,
  input logic                 push_valid,
  input logic                 rx_irq
);
  AST_IRQ_SHOWS_FULL: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> buf_full); // R5
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rx_irq |=> !rx_irq); // R5
  AST_IRQ_NOT_IN_FIFO: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> !$past(fifo_mode)); // R5
  AST_PUSH_EMPTY_BUF: assert property (@(posedge clk) disable iff (rst)
    push_valid |-> !buf_full); // R6
  AST_PUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    push_valid |=> !push_valid); // R6
  AST_PUSH_KEEPS_HOLD: assert property (@(posedge clk) disable iff (rst)
    push_valid |-> $stable(hold_data)); // R6
  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    rd_strobe |=> (!buf_full || rx_irq)); // R7
  AST_OVERRUN_ON_WORD: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> rx_irq); // R8
  AST_HOLD_ONLY_ON_WORD: assert property (@(posedge clk) disable iff (rst)
    !rx_irq |-> $stable(hold_data)); // R2
endmodule

bind uart_os_rx uart_os_rx_chk #(.DATA_BITS(DATA_BITS)) i_chk (
  .clk(clk), .rst(rst), .fifo_mode(fifo_mode), .rd_strobe(rd_strobe),
  .hold_data(hold_data), .buf_full(buf_full), .overrun(overrun),
  .push_valid(push_valid), .rx_irq(rx_irq)
);

// File: tb/test_uart_os_rx.sv
module test_uart_os_rx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b0;
  logic       rx_in = 1'b1;
  logic       fifo_mode = 1'b0;
  logic       rd_strobe = 1'b0;
  logic [7:0] hold_data;
  logic       buf_full;
  logic       overrun;
  logic       frame_err;
  logic [7:0] push_data;
  logic       push_valid;
  logic       rx_irq;

  int total = 0;
  int bad = 0;
  int push_seen = 0;
  int irq_seen = 0;
  logic [7:0] push_last = '0;
  int cycles = 0;

  logic [7:0] m_hold = '0;
  logic       m_full = 1'b0;
  logic       m_ovr = 1'b0;

  always #4 clk = ~clk;

  uart_os_rx i_uart_os_rx (
    .clk(clk), .rst(rst), .tick16(tick16), .rx_in(rx_in),
    .fifo_mode(fifo_mode), .rd_strobe(rd_strobe),
    .hold_data(hold_data), .buf_full(buf_full), .overrun(overrun),
    .frame_err(frame_err), .push_data(push_data), .push_valid(push_valid),
    .rx_irq(rx_irq)
  );

  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (push_valid) begin
      push_seen <= push_seen + 1;
      push_last <= push_data;
    end
    if (rx_irq) irq_seen <= irq_seen + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic voted(input logic b, input int glen);
    return (glen >= 2) ? ~b : b;
  endfunction

  function automatic logic [7:0] expect_word(input logic [7:0] d, input int gbit, input int glen);
    logic [7:0] r = d;
    if (gbit >= 0 && gbit < 8) r[gbit] = voted(d[gbit], glen);
    return r;
  endfunction

  task automatic tick_once();
    repeat (3) @(negedge clk);
    tick16 = 1'b1;
    @(negedge clk);
    tick16 = 1'b0;
  endtask

  task automatic idle_ticks(input int n);
    for (int i = 0; i < n; i++) tick_once();
  endtask

  // gbit: data bit to disturb (-1 none); glen: enables flipped from the 9th on
  task automatic send_frame(input logic [7:0] d, input logic stop_b, input int gbit, input int glen);
    logic [9:0] bits = {stop_b, d, 1'b0};
    for (int i = 0; i < 10; i++) begin
      for (int t = 0; t < 16; t++) begin
        rx_in = bits[i] ^ ((i == gbit + 1) && gbit >= 0 && t >= 8 && t < 8 + glen);
        tick_once();
      end
    end
  endtask

  task automatic do_read();
    @(negedge clk);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    m_full = 1'b0;
    m_ovr  = 1'b0;
  endtask

  task automatic frame_and_check(input string tag, input logic [7:0] d, input int gbit, input int glen);
    int p0 = push_seen;
    int i0 = irq_seen;
    logic [7:0] w = expect_word(d, gbit, glen);
    send_frame(d, 1'b1, gbit, glen);
    rx_in = 1'b1;
    idle_ticks(2);
    if (fifo_mode) begin
      check({tag, " R6 push count"}, push_seen - p0, 1);
      check({tag, " R6 push data"}, push_last, w);
      check({tag, " R5 no irq in fifo mode"}, irq_seen - i0, 0);
      m_full = 1'b0;
    end else begin
      check({tag, " R5 irq count"}, irq_seen - i0, 1);
      check({tag, " R2 no push"}, push_seen - p0, 0);
      m_ovr  = m_ovr | m_full;
      m_full = 1'b1;
      m_hold = w;
    end
    check({tag, " R2 hold"}, hold_data, m_hold);
    check({tag, " R2 full"}, buf_full, m_full);
    check({tag, " R8 overrun"}, overrun, m_ovr);
    check({tag, " R9 frame_err"}, frame_err, 0);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (cycles > 150000) begin
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    int p0;
    int i0;
    logic [7:0] d;
    int gb;
    int gl;
    void'($urandom(32'h5eed_0042));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 hold", hold_data, 0);
    check("R1 push_data", push_data, 0);
    check("R1 flags", {buf_full, overrun, frame_err, push_valid, rx_irq}, 0);
    idle_ticks(3);

    // R2 plain frame, LSB first
    frame_and_check("R2 a5", 8'hA5, -1, 0);
    // R8 second frame while full -> overrun
    frame_and_check("R8 3c", 8'h3C, -1, 0);
    // R7 read clears full and overrun
    do_read();
    @(negedge clk);
    check("R7 full cleared", buf_full, 0);
    check("R7 overrun cleared", overrun, 0);
    // R3 single flipped sample ignored, two flipped samples invert
    frame_and_check("R3 one", 8'h0F, 2, 1);
    do_read();
    frame_and_check("R3 two", 8'h0F, 5, 2);
    do_read();

    // R4 short start pulse
    p0 = push_seen; i0 = irq_seen;
    rx_in = 1'b0; idle_ticks(4);
    rx_in = 1'b1; idle_ticks(40);
    check("R4 no push", push_seen - p0, 0);
    check("R4 no irq", irq_seen - i0, 0);
    check("R4 outputs kept", {buf_full, overrun, frame_err}, 0);
    frame_and_check("R4 after noise", 8'h81, -1, 0);
    do_read();

    // R6 fifo mode
    fifo_mode = 1'b1;
    frame_and_check("R6 5a", 8'h5A, -1, 0);
    fifo_mode = 1'b0;

    // R9 bad stop bit, R10 line held low afterwards
    p0 = push_seen; i0 = irq_seen;
    send_frame(8'h77, 1'b0, -1, 0);
    idle_ticks(40);
    check("R9 frame_err set", frame_err, 1);
    check("R9 hold word", hold_data, 8'h77);
    rx_in = 1'b1;
    idle_ticks(20);
    check("R10 single frame irq", irq_seen - i0, 1);
    check("R10 no push", push_seen - p0, 0);
    m_hold = 8'h77; m_full = 1'b1;
    do_read();
    frame_and_check("R9 clears", 8'hC3, -1, 0);
    do_read();

    // random mix
    for (int n = 0; n < 30; n++) begin
      d  = 8'($urandom);
      fifo_mode = ($urandom % 3) == 0;
      if (($urandom % 2) == 0) do_read();
      gb = ($urandom % 4 == 0) ? int'($urandom % 8) : -1;
      gl = int'($urandom % 3);
      frame_and_check("Rnd R2", d, gb, gl);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule